// File: doc/BRIEF.md
# Inhibitable Parallel/Serial-In Shift Register

This block is an eight-stage shift register with a single serial output taken from its final stage. On each enabled rising edge of the system clock it either captures a full parallel word into all stages, or moves every stage one place toward the output while a fresh serial bit enters the first stage. A mode input chooses between the two.

An inhibit input holds the register with the system clock still running. This lets a free-running clock drive the block while a controller stops and restarts shifting on demand. The inhibit acts as a synchronous enable, so no clock is ever gated.

An active-low clear empties every stage at once, with no clock edge needed. It overrides all other inputs for as long as it is held low. Its release is synchronised to the system clock before it reaches the stages. The usual use is parallel-to-serial conversion: load a word, then clock it out one bit per enabled edge, last stage first.

Top module: `gated_piso_shreg`

## Requirements
- R1: With `inhibit` low and `shift_nload` high, each rising edge of `clk` moves stage i into stage i+1, and `ser_in` enters stage 0.
- R2: With `inhibit` low and `shift_nload` low, a rising edge of `clk` copies `par_in[i]` into stage i for every i. Stage 7 (`WIDTH-1`) is the stage driven onto `ser_out`.
- R3: During a parallel load, the value on `ser_in` has no effect on any stage.
- R4: With `inhibit` high, rising edges of `clk` leave every stage unchanged, whatever the values of `shift_nload`, `ser_in` and `par_in`.
- R5: When `clr_n` goes low, all stages become zero and `ser_out` reads 0 without waiting for a clock edge.
- R6: While `clr_n` is low, requested loads and shifts have no effect, and every stage stays zero.
- R7: After `clr_n` rises, the first two rising edges of `clk` leave the stages at zero. The third rising edge is the first that performs a load or shift.
- R8: After a parallel load, successive shift edges present `par_in[7]`, `par_in[6]`, and so on down to `par_in[0]` on `ser_out`.
- R9: The stages are zero after reset, and `ser_out` always shows the value of stage 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock; stages change on its rising edge |
| clr_n | input | 1 | Active-low clear: asserts asynchronously, releases synchronously |
| shift_nload | input | 1 | 1 = serial shift, 0 = parallel load |
| inhibit | input | 1 | 1 = hold all stages on this edge |
| ser_in | input | 1 | Serial bit that enters stage 0 on a shift |
| par_in | input | WIDTH (8) | Parallel word; bit i goes to stage i on a load |
| ser_out | output | 1 | Contents of the last stage |

## Verification
Clear can be asserted in the same cycle that an enabled load or shift is requested. Inhibit and a pending load can also meet on one edge. The bench provokes the first case by dropping `clr_n` halfway through a cycle, while an all-ones load is still presented with the inhibit low. It then requires `ser_out` to read zero before the next edge and through every edge while the clear is held. The second case is judged by loading a word, presenting a different word with the inhibit high, and then shifting out all eight stages against a reference model.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

  // Operation selected for the coming clock edge
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } shreg_op_e;

endpackage

// File: rtl/shreg_clr_sync.sv
// Clear conditioner: asserts asynchronously, releases after SYNC_STAGES edges.
module shreg_clr_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic rst_n_o
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sync_q;
  logic [TOP:0] sync_d;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[TOP-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[TOP];

endmodule

// File: rtl/shreg_ctrl.sv
// Turns the mode and inhibit inputs into the operation for the next edge.
module shreg_ctrl
  import shreg_pkg::*;
(
  input  logic      inhibit,
  input  logic      shift_nload,
  output shreg_op_e op,
  output logic      adv_en
);

  always_comb begin
    if (inhibit) begin
      op = OP_HOLD;
    end else if (shift_nload) begin
      op = OP_SHIFT;
    end else begin
      op = OP_LOAD;
    end
  end

  assign adv_en = (op != OP_HOLD);

endmodule

// File: rtl/shreg_stages.sv
// Storage stages with a per-stage next-value mux.
module shreg_stages
  import shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  shreg_op_e        op,
  input  logic             adv_en,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] stage_q
);

  logic [WIDTH-1:0] stage_d;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_stage
      logic upstream;
      logic nxt;

      if (g == 0) begin : g_head
        assign upstream = ser_in;
      end else begin : g_body
        assign upstream = stage_q[g-1];
      end

      always_comb begin
        case (op)
          OP_SHIFT: nxt = upstream;
          OP_LOAD:  nxt = par_in[g];
          default:  nxt = stage_q[g];
        endcase
      end

      assign stage_d[g] = nxt;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (adv_en) begin
      stage_q <= stage_d;
    end
  end

endmodule

// File: rtl/gated_piso_shreg.sv
module gated_piso_shreg
  import shreg_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             shift_nload,
  input  logic             inhibit,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out
);

  localparam int LAST = WIDTH - 1;

  logic             rst_int_n;
  shreg_op_e        op;
  logic             adv_en;
  logic [WIDTH-1:0] stage_q;

  shreg_clr_sync #(.SYNC_STAGES(SYNC_STAGES)) u_clr (
    .clk     (clk),
    .clr_n   (clr_n),
    .rst_n_o (rst_int_n)
  );

  shreg_ctrl u_ctrl (
    .inhibit     (inhibit),
    .shift_nload (shift_nload),
    .op          (op),
    .adv_en      (adv_en)
  );

  shreg_stages #(.WIDTH(WIDTH)) u_stages (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .op      (op),
    .adv_en  (adv_en),
    .ser_in  (ser_in),
    .par_in  (par_in),
    .stage_q (stage_q)
  );

  assign ser_out = stage_q[LAST];

endmodule

// File: rtl/shreg_checker.sv
module shreg_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             clr_n,
  input logic             rst_int_n,
  input logic             inhibit,
  input logic             shift_nload,
  input logic             ser_in,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] stage_q,
  input logic             ser_out
);

  // R5 / R6: a held clear keeps every stage at zero (sampled mid-cycle)
  always @(negedge clk) begin
    if (clr_n === 1'b0) begin
      assert_clear_zero_R6: assert (stage_q == '0 && ser_out == 1'b0);
    end
  end

  // R4: inhibit holds every stage
  assert_inhibit_hold_R4: assert property (
    @(posedge clk) disable iff (!clr_n || !rst_int_n)
    (rst_int_n && inhibit) |=> $stable(stage_q));

  // R2 / R3: load copies the parallel word, the serial input is ignored
  assert_load_word_R2: assert property (
    @(posedge clk) disable iff (!clr_n || !rst_int_n)
    (rst_int_n && !inhibit && !shift_nload) |=> (stage_q == $past(par_in)));

  // R1: shift moves toward the last stage, serial bit into stage 0
  assert_shift_move_R1: assert property (
    @(posedge clk) disable iff (!clr_n || !rst_int_n)
    (rst_int_n && !inhibit && shift_nload) |=>
      (stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_in)}));

  // R7: when the internal release takes effect the stages are still empty
  assert_release_empty_R7: assert property (
    @(posedge clk) disable iff (!clr_n)
    $rose(rst_int_n) |-> (stage_q == '0));

endmodule

bind gated_piso_shreg shreg_checker #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .clr_n       (clr_n),
  .rst_int_n   (rst_int_n),
  .inhibit     (inhibit),
  .shift_nload (shift_nload),
  .ser_in      (ser_in),
  .par_in      (par_in),
  .stage_q     (stage_q),
  .ser_out     (ser_out)
);

// File: tb/gated_piso_shreg_tb_top.sv
`timescale 1ns/1ps
module gated_piso_shreg_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clr_n;
  logic         shift_nload;
  logic         inhibit;
  logic         ser_in;
  logic [W-1:0] par_in;
  logic         ser_out;

  logic [W-1:0] ref_q;
  int           n_chk = 0;
  int           n_bad = 0;

  always #2.5 clk = ~clk;

  gated_piso_shreg #(.WIDTH(W)) dut_i (
    .clk         (clk),
    .clr_n       (clr_n),
    .shift_nload (shift_nload),
    .inhibit     (inhibit),
    .ser_in      (ser_in),
    .par_in      (par_in),
    .ser_out     (ser_out)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock with the given controls; reference updated per R1/R2/R4
  task automatic step(input logic sl, input logic inh, input logic sin,
                      input logic [W-1:0] par, input string tag);
    @(negedge clk);
    shift_nload = sl; inhibit = inh; ser_in = sin; par_in = par;
    @(posedge clk);
    if (!inh) begin
      if (sl) ref_q = {ref_q[W-2:0], sin};
      else    ref_q = par;
    end
    #1;
    check(ser_out, ref_q[W-1], tag);
  endtask

  // shift all stages out and compare against the reference (R9)
  task automatic drain(input string tag);
    for (int i = 0; i < W; i++) step(1'b1, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic do_clear_release();
    @(negedge clk);
    clr_n = 1'b0; inhibit = 1'b1;
    ref_q = '0;
    @(negedge clk);
    clr_n = 1'b1; inhibit = 1'b0; shift_nload = 1'b0; par_in = '1;
    for (int e = 0; e < 2; e++) begin
      @(posedge clk); #1;
      check(ser_out, 1'b0, "R7 edge before release");
    end
    @(posedge clk);
    ref_q = '1;
    #1;
    check(ser_out, 1'b1, "R7 first active edge");
    @(negedge clk); inhibit = 1'b1;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1; check(ser_out, 1'b0, "R9 reset state");
    @(negedge clk); clr_n = 1'b1;
    repeat (3) @(posedge clk);
    #1; check(ser_out, 1'b0, "R9 idle after release");
  endtask

  task automatic t_load_out();
    logic [W-1:0] word = 8'hB4;
    step(1'b0, 1'b0, 1'b0, word, "R2 load");
    for (int i = W - 1; i >= 1; i--) begin
      step(1'b1, 1'b0, 1'b0, '0, "R8 shift out");
      check(ser_out, word[i-1], "R8 bit order");
    end
  endtask

  task automatic t_serial_in();
    logic [W-1:0] pat = 8'b1100_1011;
    for (int i = 0; i < W; i++) step(1'b1, 1'b0, pat[i], '0, "R1 shift in");
    check(ser_out, pat[0], "R1 first bit reached last stage");
    drain("R1 drain");
  endtask

  task automatic t_load_ignores_serial();
    step(1'b0, 1'b0, 1'b1, 8'h00, "R3 load zero with serial high");
    drain("R3 drain");
    step(1'b0, 1'b0, 1'b0, 8'hFF, "R3 load ones with serial low");
    drain("R3 drain ones");
  endtask

  task automatic t_inhibit();
    step(1'b0, 1'b0, 1'b0, 8'h5A, "R2 load before hold");
    step(1'b0, 1'b1, 1'b1, 8'hA5, "R4 held load");
    step(1'b1, 1'b1, 1'b1, 8'h00, "R4 held shift");
    step(1'b1, 1'b1, 1'b0, 8'hFF, "R4 held shift 2");
    drain("R4 contents kept");
  endtask

  task automatic t_clear_override();
    step(1'b0, 1'b0, 1'b0, 8'hFF, "R2 load ones");
    @(negedge clk);
    shift_nload = 1'b0; inhibit = 1'b0; par_in = '1;
    #1;
    clr_n = 1'b0;
    #1;
    check(ser_out, 1'b0, "R5 async clear");
    ref_q = '0;
    for (int e = 0; e < 3; e++) begin
      @(posedge clk); #1;
      check(ser_out, 1'b0, "R6 clear holds");
    end
    do_clear_release();
    drain("R7 loaded word after release");
  endtask

  initial begin
    clr_n = 1'b0; shift_nload = 1'b1; inhibit = 1'b1;
    ser_in = 1'b0; par_in = '0; ref_q = '0;
    t_reset();
    t_load_out();
    t_serial_in();
    t_load_ignores_serial();
    t_inhibit();
    t_clear_override();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule